// File: doc/BRIEF.md
# Multiplexed External SRAM Bus Controller

This block sits between a CPU-side request port and an external SRAM that is reached over a narrow multiplexed bus. For every accepted request it puts out the low address byte on a shared address/data bus while pulsing an address-latch strobe. It drives the high address byte on a dedicated bus for the whole access. Then it runs a data phase under an active-low read or write strobe. The requester holds its request with `req_valid` until `req_ready` pulses in the last cycle of the access.

An 8-bit control register sets four things: whether the interface owns the pins, where the external space splits into a lower and an upper sector, and the 2-bit wait code for each sector. The wait code lengthens the strobe, and its largest value also inserts a recovery cycle. Each access takes four to seven clock periods. An optional bus-hold mode makes the shared bus show the last value seen on it when nothing drives it, instead of floating. A hint input asks for a trailing address-latch pulse when the following access also goes to RAM.

Top module: `xmb_ctrl`

## Requirements
- R1: After synchronous reset the control register reads 0x00: pins inactive, `ad_oe`, `ahi_oe`, `ale` and `req_ready` low, `wr_n`/`rd_n` high, `ad_out`, `ahi_out` and `req_rdata` zero.
- R2: Control bit 7 enables the interface and `pins_active` follows it. While it is 0 the pins are not driven, strobes stay high, both bus outputs read zero and requests are never accepted (`req_ready` stays low).
- R3: The cycle after acceptance is the address cycle. In it `ale` is high, `ad_out` carries address bits 7..0 with `ad_oe` high, and neither strobe is low. `ahi_out` shows address bits 15..8 from that cycle until the next access is accepted.
- R4: Control bits 6..4 form a limit code L. For L in 1..7, addresses below L×0x2000 use the lower wait code in bits 1..0, and all other addresses use the upper wait code in bits 3..2.
- R5: With L = 0 every address uses the upper wait code in bits 3..2.
- R6: The strobe lasts 1, 2, 3 or 3 cycles for wait codes 00, 01, 10 and 11. It is preceded by the address cycle and one setup cycle. A whole access takes 4, 5, 6 or 7 cycles.
- R7: Wait code 11 adds one cycle between the strobe and the final cycle. In that cycle both strobes are high and the shared bus is not driven.
- R8: On a write, `ad_out` drives the write data with `ad_oe` high from the setup cycle through the last strobe cycle. `wr_n` is low exactly during the strobe cycles and `rd_n` stays high.
- R9: On a read, `ad_oe` is low after the address cycle and `rd_n` is low exactly during the strobe cycles. `req_rdata` takes the value of `ad_in` at the clock edge that ends the last strobe cycle.
- R10: `req_ready` is high for exactly one cycle, the final cycle of each access.
- R11: `ale` pulses again in the final cycle exactly when `next_is_ram` is high in that cycle.
- R12: With `bus_hold_en` high and the interface enabled, `ad_keep` is high whenever `ad_oe` is low, and `ad_out` then shows the last value seen on the bus (last driven byte, or last captured read byte). With `bus_hold_en` low, `ad_keep` is low and an undriven `ad_out` reads zero.
- R13: The wait code is fixed when a request is accepted. A control write during an access affects only later accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write value |
| bus_hold_en | input | 1 | Bus-hold mode for the shared bus |
| next_is_ram | input | 1 | Following access also targets RAM |
| req_valid | input | 1 | Request present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Final cycle of the access |
| req_rdata | output | 8 | Captured read data |
| pins_active | output | 1 | Interface owns the pins |
| ad_out | output | 8 | Shared address/data bus output value |
| ad_oe | output | 1 | Shared bus output enable |
| ad_keep | output | 1 | Bus-hold is holding the shared bus |
| ad_in | input | 8 | Shared bus input value |
| ahi_out | output | 8 | High address bus |
| ahi_oe | output | 1 | High address bus output enable |
| ale | output | 1 | Address latch enable |
| wr_n | output | 1 | Active-low write strobe |
| rd_n | output | 1 | Active-low read strobe |

## Verification
The bench builds the block with its default widths: a 16-bit address and an 8-bit data bus, which give an 8-bit high address and a 13-bit sector granule. At these values a run can reach all seven limit codes and both sides of each boundary at 0x1FFF/0x2000, 0x5FFF/0x6000 and 0xDFFF/0xE000. It can also cover every wait code on both reads and writes, and the 0xFFFF top of space. A behavioural model predicts every pin in every cycle, including a control write that lands mid-access and bus-hold values after reads.

// File: rtl/xmb_pkg.sv
package xmb_pkg;

    localparam int CTL_W   = 8;
    localparam int LIMIT_W = 3;
    localparam int WAIT_W  = 2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_SETUP,
        PH_STROBE,
        PH_TAIL,
        PH_END
    } phase_e;

    typedef struct packed {
        logic               en;
        logic [LIMIT_W-1:0] lim;
        logic [WAIT_W-1:0]  w_hi;
        logic [WAIT_W-1:0]  w_lo;
    } ctl_t;

    // strobe cycles beyond the first one
    function automatic logic [1:0] extra_strobes(input logic [WAIT_W-1:0] code);
        case (code)
            2'b00:   return 2'd0;
            2'b01:   return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    // recovery cycle before the next address
    function automatic logic wants_tail(input logic [WAIT_W-1:0] code);
        return code == 2'b11;
    endfunction

endpackage

// File: rtl/xmb_cfg_reg.sv
module xmb_cfg_reg
    import xmb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wdata,
    output ctl_t             cfg
);
    always_ff @(posedge clk) begin
        if (rst)        cfg <= '0;
        else if (wr_en) cfg <= ctl_t'(wdata);
    end
endmodule

// File: rtl/xmb_sector_sel.sv
module xmb_sector_sel
    import xmb_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  ctl_t              cfg,
    output logic [WAIT_W-1:0] wcode
);
    localparam int SHIFT = ADDR_W - LIMIT_W;

    logic below;
    // the top LIMIT_W address bits compared with the limit give addr < lim << SHIFT
    assign below = addr[ADDR_W-1:SHIFT] < cfg.lim;

    always_comb begin
        if (cfg.lim == '0) wcode = cfg.w_hi;
        else if (below)    wcode = cfg.w_lo;
        else               wcode = cfg.w_hi;
    end
endmodule

// File: rtl/xmb_seq.sv
module xmb_seq
    import xmb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              req_valid,
    input  logic [WAIT_W-1:0] wcode,
    output phase_e            phase,
    output logic              accept,
    output logic              last_strobe
);
    logic [1:0] cnt;
    logic       tail_q;

    assign accept      = (phase == PH_IDLE) && enable && req_valid;
    assign last_strobe = (phase == PH_STROBE) && (cnt == 2'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cnt    <= 2'd0;
            tail_q <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: if (accept) begin
                    phase  <= PH_ADDR;
                    cnt    <= extra_strobes(wcode);
                    tail_q <= wants_tail(wcode);
                end
                PH_ADDR:  phase <= PH_SETUP;
                PH_SETUP: phase <= PH_STROBE;
                PH_STROBE: begin
                    if (cnt == 2'd0) phase <= tail_q ? PH_TAIL : PH_END;
                    else             cnt   <= cnt - 2'd1;
                end
                PH_TAIL: phase <= PH_END;
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xmb_ctrl.sv
module xmb_ctrl
    import xmb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_we,
    input  logic [CTL_W-1:0]         cfg_wdata,
    input  logic                     bus_hold_en,
    input  logic                     next_is_ram,
    input  logic                     req_valid,
    input  logic                     req_we,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     req_ready,
    output logic [DATA_W-1:0]        req_rdata,
    output logic                     pins_active,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic                     ad_keep,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [ADDR_W-DATA_W-1:0] ahi_out,
    output logic                     ahi_oe,
    output logic                     ale,
    output logic                     wr_n,
    output logic                     rd_n
);
    localparam int HI_W = ADDR_W - DATA_W;

    ctl_t              cfg;
    logic [WAIT_W-1:0] wcode;
    phase_e            phase;
    logic              accept;
    logic              last_strobe;

    logic [DATA_W-1:0] lo_q;
    logic [HI_W-1:0]   hi_q;
    logic              we_q;
    logic [DATA_W-1:0] wd_q;
    logic [DATA_W-1:0] rd_q;
    logic [DATA_W-1:0] last_q;

    logic drive_addr, drive_data, in_strobe;
    logic [DATA_W-1:0] drv_val;

    xmb_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    xmb_sector_sel #(.ADDR_W(ADDR_W)) u_sect (
        .addr  (req_addr),
        .cfg   (cfg),
        .wcode (wcode)
    );

    xmb_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .enable      (cfg.en),
        .req_valid   (req_valid),
        .wcode       (wcode),
        .phase       (phase),
        .accept      (accept),
        .last_strobe (last_strobe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
            we_q <= 1'b0;
            wd_q <= '0;
        end else if (accept) begin
            lo_q <= req_addr[DATA_W-1:0];
            hi_q <= req_addr[ADDR_W-1:DATA_W];
            we_q <= req_we;
            wd_q <= req_wdata;
        end
    end

    assign drive_addr = phase == PH_ADDR;
    assign drive_data = we_q && (phase == PH_SETUP || phase == PH_STROBE);
    assign in_strobe  = phase == PH_STROBE;
    assign drv_val    = drive_addr ? lo_q : wd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q   <= '0;
            last_q <= '0;
        end else if (last_strobe && !we_q) begin
            rd_q   <= ad_in;
            last_q <= ad_in;
        end else if (ad_oe) begin
            last_q <= drv_val;
        end
    end

    assign pins_active = cfg.en;
    assign ad_oe       = cfg.en && (drive_addr || drive_data);
    assign ad_keep     = cfg.en && bus_hold_en && !ad_oe;
    assign ad_out      = !cfg.en   ? '0 :
                         ad_oe     ? drv_val :
                         ad_keep   ? last_q : '0;
    assign ahi_oe      = cfg.en;
    assign ahi_out     = cfg.en ? hi_q : '0;
    assign ale         = cfg.en && (drive_addr || (phase == PH_END && next_is_ram));
    assign wr_n        = !(cfg.en && in_strobe && we_q);
    assign rd_n        = !(cfg.en && in_strobe && !we_q);
    assign req_ready   = phase == PH_END;
    assign req_rdata   = rd_q;
endmodule

// File: rtl/xmb_ctrl_chk.sv
module xmb_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       pins_active,
    input logic       ad_oe,
    input logic       ad_keep,
    input logic       ale,
    input logic       wr_n,
    input logic       rd_n,
    input logic       req_ready,
    input logic [7:0] ahi_out
);
    p_strobes_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(!wr_n && !rd_n));

    p_quiet_when_off_r2: assert property (@(posedge clk) disable iff (rst)
        !pins_active |-> (!ad_oe && !ale && wr_n && rd_n && !req_ready));

    p_ready_single_r10: assert property (@(posedge clk) disable iff (rst)
        req_ready |=> !req_ready);

    p_ale_no_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        ale |-> (wr_n && rd_n));

    p_read_released_r9: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !ad_oe);

    p_write_driven_r8: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> ad_oe);

    p_hi_stable_r3: assert property (@(posedge clk) disable iff (rst)
        ((!wr_n || !rd_n) && $past(!wr_n || !rd_n)) |-> $stable(ahi_out));

    p_keep_not_driving_r12: assert property (@(posedge clk) disable iff (rst)
        ad_keep |-> !ad_oe);
endmodule

bind xmb_ctrl xmb_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .pins_active (pins_active),
    .ad_oe       (ad_oe),
    .ad_keep     (ad_keep),
    .ale         (ale),
    .wr_n        (wr_n),
    .rd_n        (rd_n),
    .req_ready   (req_ready),
    .ahi_out     (ahi_out)
);

// File: tb/test_xmb_ctrl.sv
module test_xmb_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic        bus_hold_en = 1'b0;
    logic        next_is_ram = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_we = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  ad_in = '0;
    logic        req_ready, pins_active, ad_oe, ad_keep, ahi_oe, ale, wr_n, rd_n;
    logic [7:0]  req_rdata, ad_out, ahi_out;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit started = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    xmb_ctrl i_xmb_ctrl (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .bus_hold_en(bus_hold_en), .next_is_ram(next_is_ram),
        .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .req_rdata(req_rdata),
        .pins_active(pins_active), .ad_out(ad_out), .ad_oe(ad_oe),
        .ad_keep(ad_keep), .ad_in(ad_in), .ahi_out(ahi_out), .ahi_oe(ahi_oe),
        .ale(ale), .wr_n(wr_n), .rd_n(rd_n)
    );

    // ---------------- behavioural reference ----------------
    logic [7:0]  m_cfg = '0;
    int          m_pos = 0;
    int          m_len = 0;
    int          m_str = 0;
    logic        m_we = 0;
    logic [15:0] m_addr = '0;
    logic [7:0]  m_wd = '0, m_last = '0, m_rd = '0, m_ahi = '0;

    function automatic int strobe_cycles(input logic [1:0] code);
        if (code == 2'b00) return 1;
        if (code == 2'b01) return 2;
        return 3;
    endfunction

    // R4 R5: sector choice from the limit code
    function automatic logic [1:0] pick_code(input logic [7:0] c, input logic [15:0] a);
        int lim = int'(c[6:4]);
        if (lim == 0) return c[3:2];
        if (int'(a) < lim * 32'h2000) return c[1:0];
        return c[3:2];
    endfunction

    function automatic bit m_addr_phase();  return m_pos == 1; endfunction
    function automatic bit m_data_drive();  return m_we && m_pos >= 2 && m_pos <= 2 + m_str; endfunction
    function automatic bit m_in_strobe();   return m_pos >= 3 && m_pos <= 2 + m_str; endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cfg = '0; m_pos = 0; m_len = 0; m_str = 0; m_we = 0;
            m_addr = '0; m_wd = '0; m_last = '0; m_rd = '0; m_ahi = '0;
        end else begin
            if (m_cfg[7] && m_addr_phase())      m_last = m_addr[7:0];
            else if (m_cfg[7] && m_data_drive()) m_last = m_wd;
            if (!m_we && m_pos == 2 + m_str && m_pos != 0) begin
                m_rd = ad_in;
                m_last = ad_in;
            end
            if (m_pos == 0) begin
                if (m_cfg[7] && req_valid) begin
                    logic [1:0] code;
                    code   = pick_code(m_cfg, req_addr);
                    m_str  = strobe_cycles(code);
                    m_len  = 3 + m_str + ((code == 2'b11) ? 1 : 0);
                    m_addr = req_addr;
                    m_we   = req_we;
                    m_wd   = req_wdata;
                    m_ahi  = req_addr[15:8];
                    m_pos  = 1;
                end
            end else if (m_pos == m_len) begin
                m_pos = 0;
            end else begin
                m_pos = m_pos + 1;
            end
            if (cfg_we) m_cfg = cfg_wdata;
        end
    end

    task automatic cmp(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: actual=%h expected=%h", req, what, cycles, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started && !finished) begin
            bit on, drv, stb;
            logic [7:0] e_ad;
            on  = m_cfg[7];
            drv = on && (m_addr_phase() || m_data_drive());
            stb = on && m_in_strobe();
            e_ad = !on ? 8'h00 : m_addr_phase() ? m_addr[7:0] : drv ? m_wd :
                   bus_hold_en ? m_last : 8'h00;
            cmp("R2",     "pins_active", 16'(pins_active), 16'(on));
            cmp("R3 R8 R9", "ad_oe",     16'(ad_oe), 16'(drv));
            cmp("R3 R8 R12", "ad_out",   16'(ad_out), 16'(e_ad));
            cmp("R12",    "ad_keep",     16'(ad_keep), 16'(on && bus_hold_en && !drv));
            cmp("R3",     "ahi_oe",      16'(ahi_oe), 16'(on));
            cmp("R3",     "ahi_out",     16'(ahi_out), 16'(on ? m_ahi : 8'h00));
            cmp("R3 R11", "ale",         16'(ale),
                16'(on && (m_pos == 1 || (m_pos != 0 && m_pos == m_len && next_is_ram))));
            cmp("R6 R8",  "wr_n",        16'(wr_n), 16'(!(stb && m_we)));
            cmp("R6 R9",  "rd_n",        16'(rd_n), 16'(!(stb && !m_we)));
            cmp("R6 R7 R10", "req_ready", 16'(req_ready), 16'(m_pos != 0 && m_pos == m_len));
            cmp("R9",     "req_rdata",   16'(req_rdata), 16'(m_rd));
        end
    end

    // ---------------- stimulus ----------------
    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic set_cfg(input logic [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic access(input logic [15:0] a, input logic we, input logic [7:0] wd,
                          input logic [7:0] din, input logic nram);
        int guard = 0;
        req_addr = a; req_we = we; req_wdata = wd; ad_in = din; next_is_ram = nram;
        req_valid = 1'b1;
        do begin
            @(negedge clk);
            guard++;
        end while (!req_ready && guard < 40);
        step();
        req_valid = 1'b0;
        step();
    endtask

    initial begin
        step(); step();
        started = 1;
        step();
        rst = 1'b0;
        step();
        // R1: reset state
        cmp("R1", "reset ready", 16'(req_ready), 16'h0);
        cmp("R1", "reset strobes", 16'({wr_n, rd_n}), 16'h3);
        // R2: disabled, request never accepted
        req_valid = 1'b1; req_addr = 16'h1234;
        repeat (6) step();
        req_valid = 1'b0;
        // R5: limit zero, upper code sweep, R6 R7 R8 R9 R11
        for (int c = 0; c < 4; c++) begin
            set_cfg(8'h80 | 8'(c << 2));
            access(16'h0000 + 16'(c), 1'b1, 8'hA0 + 8'(c), 8'h00, c[0]);
            access(16'hF0F0, 1'b0, 8'h00, 8'h5A ^ 8'(c), !c[0]);
        end
        // R4: boundaries, lower code 10, upper code 01
        for (int l = 1; l < 8; l++) begin
            set_cfg(8'h80 | 8'(l << 4) | 8'h06);
            access(16'(l * 16'h2000 - 1), 1'b0, 8'h00, 8'h11 * 8'(l), 1'b0);
            access(16'(l * 16'h2000), 1'b1, 8'h33, 8'h00, 1'b1);
        end
        set_cfg(8'hF7);
        access(16'hFFFF, 1'b0, 8'h00, 8'hC3, 1'b1);
        access(16'h0000, 1'b1, 8'h3C, 8'h00, 1'b0);
        // R12: bus hold after a read and after a write
        bus_hold_en = 1'b1;
        set_cfg(8'h8C);
        access(16'h4321, 1'b0, 8'h00, 8'h9E, 1'b0);
        repeat (2) step();
        access(16'h8765, 1'b1, 8'h7D, 8'h00, 1'b1);
        repeat (2) step();
        bus_hold_en = 1'b0;
        step();
        // R13: control write in the middle of an access
        set_cfg(8'h8C);
        fork
            access(16'h2222, 1'b0, 8'h00, 8'h44, 1'b0);
            begin
                step();
                set_cfg(8'h80);
            end
        join
        access(16'h2223, 1'b1, 8'h55, 8'h00, 1'b0);
        // R2: disabling releases the pins
        set_cfg(8'h00);
        req_valid = 1'b1;
        repeat (4) step();
        req_valid = 1'b0;
        step();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog expired at cycle %0d: actual=running expected=done", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule